// File: doc/BRIEF.md
# 32-bit SEC-DED Memory Word Protector

This block guards 32-bit memory words with a 7-bit single-error-correcting, double-error-detecting check word. On the write path it takes a data word and produces the check word that is stored next to it, so memory holds a 39-bit word. On the read path it takes the 39-bit word back from memory and computes a 7-bit syndrome. A single flipped data bit is repaired on the output. A single flipped check bit is reported while the data passes through untouched. Any pair of flipped bits is reported as uncorrectable. Two check bits are stored inverted, so a memory stuck at all zeros or all ones never looks like a valid word.

All inputs are captured in an input register when `load` is high, and every output is registered one clock later. A single operation code picks what the block does with the captured word: encode it, correct it, merge it with new write data byte by byte, or pass the captured data and check bits back out unchanged for diagnosis. The merge operation lets a partial write run as one read-modify-write step. New bytes replace the corrected read bytes and a fresh check word is produced for the merged result.

Top module: `edac32_top`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero on the next rising edge, and they stay zero while `rst` is held.
- R2: `op`, `data_in`, `check_in`, `merge_data` and `byte_sel` are captured on a rising edge with `load` high. Outputs reflect the captured values at the following rising edge. While `load` is low the captured values, and so the outputs, do not change.
- R3: Operation 2'b00 (encode) gives `data_out` = captured data and `check_out` = P ^ 7'b0001100. P[r] is the XOR of every data bit j whose column has bit r set. The column of data bit j (j = 0..31) is the (j+1)-th smallest 7-bit value with exactly three ones, so bit 0 is 7'b0000111. In this mode `syndrome`, `single_err` and `double_err` are zero.
- R4: Operation 2'b01 (correct) gives `syndrome` = encode(captured data) ^ captured check bits. A zero syndrome leaves both flags low and passes the data through unchanged.
- R5: In correct mode, a syndrome equal to the column of data bit j raises `single_err` and inverts bit j on `data_out`.
- R6: In correct mode, a syndrome with exactly one bit set raises `single_err` and leaves the data unchanged. The set bit is the index of the failing check bit.
- R7: In correct mode, any other nonzero syndrome raises `double_err` and leaves the data unchanged. This covers every two-bit error over the 39 bits: data/data, check/check and data/check.
- R8: A 39-bit memory word of all zeros, or of all ones, raises `double_err` in correct mode.
- R9: `single_err` and `double_err` are never high together.
- R10: Operation 2'b10 (merge) takes byte k (data bits 8k+7..8k) from `merge_data` when `byte_sel[k]` is 1 and from the corrected read data otherwise. `check_out` is the R3 encoding of the merged word, and `syndrome` and the flags are those of the read word.
- R11: Operation 2'b11 (diagnostic) gives `data_out` = captured data, `check_out` = captured check bits unchanged, and zero `syndrome` and flags.
- R12: In correct mode `check_out` is the R3 encoding of `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture enable for all inputs |
| op | input | 2 | Operation: 00 encode, 01 correct, 10 merge, 11 diagnostic |
| data_in | input | 32 | Write data or data read from memory |
| check_in | input | 7 | Check bits read from memory |
| merge_data | input | 32 | New write data for a merge |
| byte_sel | input | 4 | Per-byte select of merge data |
| data_out | output | 32 | Encoded, corrected, merged or captured data |
| check_out | output | 7 | Generated check word, or captured check bits in diagnostic mode |
| syndrome | output | 7 | Syndrome of the read word (correct and merge) |
| single_err | output | 1 | Correctable single-bit error seen |
| double_err | output | 1 | Uncorrectable error seen |

## Verification
The hardest case to reach from the ports is a particular corrupted memory word: every double-bit position, and the stuck-at all-zeros and all-ones words, must arrive with exactly the right check bits. The bench therefore builds a valid 39-bit codeword with its own encoder, written from the R3 column rule. It then XORs in error masks for all 39 single positions and all 741 pairs, plus the two gross patterns applied raw. Merge is driven with every byte-select pattern on top of a corrected single error, so that repaired bytes and replaced bytes are seen side by side.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int COL_WT  = 3;
  localparam int OP_W    = 2;
  // Stored-inverted check bits: keeps all-0 and all-1 words off the code.
  localparam logic [CHK_W-1:0] CHK_INV = 7'b0001100;

  typedef enum logic [OP_W-1:0] {
    OP_ENCODE  = 2'b00,
    OP_CORRECT = 2'b01,
    OP_MERGE   = 2'b10,
    OP_DIAG    = 2'b11
  } edac_op_e;

  // Column of data bit idx: idx-th smallest CHK_W-bit value of weight COL_WT.
  function automatic logic [CHK_W-1:0] h_col(input int idx);
    logic [CHK_W-1:0] res;
    logic [CHK_W-1:0] cand;
    int seen;
    res  = '0;
    seen = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      cand = CHK_W'(v);
      if ($countones(cand) == COL_WT) begin
        if (seen == idx) res = cand;
        seen++;
      end
    end
    return res;
  endfunction

  // Data bits that feed parity row r.
  function automatic logic [DATA_W-1:0] row_mask(input int r);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int j = 0; j < DATA_W; j++) begin
      c = h_col(j);
      m[j] = c[r];
    end
    return m;
  endfunction
endpackage

// File: rtl/edac_parity.sv
module edac_parity
  import edac_pkg::*;
#(
  parameter bit APPLY_INV = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  localparam logic [CHK_W-1:0] INV = APPLY_INV ? CHK_INV : '0;

  logic [CHK_W-1:0] par;

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] RMASK = row_mask(r);
    assign par[r] = ^(data & RMASK);
  end

  assign chk = par ^ INV;
endmodule

// File: rtl/edac_decode.sv
module edac_decode
  import edac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  check,
  output logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] corr,
  output logic              single_hit,
  output logic              double_hit
);
  logic [CHK_W-1:0]  regen;
  logic [DATA_W-1:0] flip;
  logic              chk_hit;

  edac_parity #(.APPLY_INV(1'b1)) u_regen (
    .data (data),
    .chk  (regen)
  );

  // Inversion cancels: both sides carry the same mask.
  assign syn = regen ^ check;

  for (genvar j = 0; j < DATA_W; j++) begin : g_flip
    localparam logic [CHK_W-1:0] COL = h_col(j);
    assign flip[j] = (syn == COL);
  end

  assign chk_hit    = $onehot(syn);
  assign single_hit = (|flip) | chk_hit;
  assign double_hit = (syn != '0) && !single_hit;
  assign corr       = data ^ flip;

  // R5: at most one data bit is ever repaired
  assert_one_flip_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flip));

  // R6: a check-bit hit never also repairs data
  assert_chk_no_flip_R6: assert property (@(posedge clk) disable iff (rst)
    chk_hit |-> (corr == data));
endmodule

// File: rtl/edac_merge.sv
module edac_merge
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0]  rd_word,
  input  logic [DATA_W-1:0]  wr_word,
  input  logic [N_BYTES-1:0] sel,
  output logic [DATA_W-1:0]  merged
);
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    assign merged[k*BYTE_W +: BYTE_W] =
      sel[k] ? wr_word[k*BYTE_W +: BYTE_W] : rd_word[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/edac32_top.sv
module edac32_top
  import edac_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [OP_W-1:0]     op,
  input  logic [DATA_W-1:0]   data_in,
  input  logic [CHK_W-1:0]    check_in,
  input  logic [DATA_W-1:0]   merge_data,
  input  logic [N_BYTES-1:0]  byte_sel,
  output logic [DATA_W-1:0]   data_out,
  output logic [CHK_W-1:0]    check_out,
  output logic [CHK_W-1:0]    syndrome,
  output logic                single_err,
  output logic                double_err
);
  edac_op_e           op_q;
  logic [DATA_W-1:0]  data_q;
  logic [CHK_W-1:0]   check_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [N_BYTES-1:0] sel_q;

  logic [CHK_W-1:0]   dec_syn;
  logic [DATA_W-1:0]  dec_corr;
  logic               dec_single;
  logic               dec_double;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  data_nx;
  logic [CHK_W-1:0]   enc_nx;
  logic [CHK_W-1:0]   check_nx;
  logic [CHK_W-1:0]   syn_nx;
  logic               single_nx;
  logic               double_nx;

  // Input capture register
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_ENCODE;
      data_q  <= '0;
      check_q <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else if (load) begin
      op_q    <= edac_op_e'(op);
      data_q  <= data_in;
      check_q <= check_in;
      wdata_q <= merge_data;
      sel_q   <= byte_sel;
    end
  end

  edac_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .data       (data_q),
    .check      (check_q),
    .syn        (dec_syn),
    .corr       (dec_corr),
    .single_hit (dec_single),
    .double_hit (dec_double)
  );

  edac_merge u_merge (
    .rd_word (dec_corr),
    .wr_word (wdata_q),
    .sel     (sel_q),
    .merged  (merged)
  );

  always_comb begin
    data_nx   = data_q;
    syn_nx    = '0;
    single_nx = 1'b0;
    double_nx = 1'b0;
    unique case (op_q)
      OP_ENCODE: data_nx = data_q;
      OP_CORRECT: begin
        data_nx   = dec_corr;
        syn_nx    = dec_syn;
        single_nx = dec_single;
        double_nx = dec_double;
      end
      OP_MERGE: begin
        data_nx   = merged;
        syn_nx    = dec_syn;
        single_nx = dec_single;
        double_nx = dec_double;
      end
      OP_DIAG: data_nx = data_q;
      default: data_nx = data_q;
    endcase
  end

  edac_parity #(.APPLY_INV(1'b1)) u_enc (
    .data (data_nx),
    .chk  (enc_nx)
  );

  assign check_nx = (op_q == OP_DIAG) ? check_q : enc_nx;

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out   <= '0;
      check_out  <= '0;
      syndrome   <= '0;
      single_err <= 1'b0;
      double_err <= 1'b0;
    end else begin
      data_out   <= data_nx;
      check_out  <= check_nx;
      syndrome   <= syn_nx;
      single_err <= single_nx;
      double_err <= double_nx;
    end
  end

  // R1: reset clears all outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (data_out == '0 && check_out == '0 && syndrome == '0 &&
             !single_err && !double_err));

  // R9: flags mutually exclusive
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(single_err && double_err));

  // R11: diagnostic passes captured bits unchanged
  assert_diag_pass_R11: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_DIAG) |=> (data_out == $past(data_q) &&
                           check_out == $past(check_q) &&
                           !single_err && !double_err));

  // R7: uncorrectable word leaves data untouched
  assert_double_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_CORRECT && dec_double) |=>
      (double_err && data_out == $past(data_q)));

  // R5: correction changes at most one bit
  assert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_CORRECT) |=> ($countones(data_out ^ $past(data_q)) <= 1));

  // R3: encode mode keeps data and raises no flag
  assert_encode_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_ENCODE) |=> (data_out == $past(data_q) && syndrome == '0 &&
                             !single_err && !double_err));

  // R10: selected bytes come from merge data
  for (genvar k = 0; k < N_BYTES; k++) begin : g_merge_chk
    assert_merge_byte_R10: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_MERGE && sel_q[k]) |=>
        (data_out[k*BYTE_W +: BYTE_W] == $past(wdata_q[k*BYTE_W +: BYTE_W])));
  end
endmodule

// File: tb/tb_edac32_top.sv
`timescale 1ns/1ps
module tb_edac32_top;
  localparam real CLK_NS = 8.0;
  localparam logic [1:0] T_ENC = 2'b00, T_COR = 2'b01, T_MRG = 2'b10, T_DIA = 2'b11;
  localparam logic [6:0] T_INV = 7'b0001100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] data_in = '0;
  logic [6:0]  check_in = '0;
  logic [31:0] merge_data = '0;
  logic [3:0]  byte_sel = '0;
  logic [31:0] data_out;
  logic [6:0]  check_out;
  logic [6:0]  syndrome;
  logic        single_err;
  logic        double_err;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  edac32_top dut (
    .clk(clk), .rst(rst), .load(load), .op(op),
    .data_in(data_in), .check_in(check_in),
    .merge_data(merge_data), .byte_sel(byte_sel),
    .data_out(data_out), .check_out(check_out), .syndrome(syndrome),
    .single_err(single_err), .double_err(double_err)
  );

  // Reference column rule (R3)
  function automatic logic [6:0] ref_col(input int idx);
    logic [6:0] c;
    int seen = 0;
    logic [6:0] res = '0;
    for (int v = 0; v < 128; v++) begin
      c = 7'(v);
      if ($countones(c) == 3) begin
        if (seen == idx) res = c;
        seen++;
      end
    end
    return res;
  endfunction

  function automatic logic [6:0] ref_enc(input logic [31:0] d);
    logic [6:0] p = '0;
    for (int j = 0; j < 32; j++)
      if (d[j]) p = p ^ ref_col(j);
    return p ^ T_INV;
  endfunction

  // Expected outputs from the requirements
  task automatic model(input logic [1:0] mop, input logic [31:0] rd, input logic [6:0] rc,
                       input logic [31:0] wd, input logic [3:0] be,
                       output logic [31:0] ed, output logic [6:0] ec, output logic [6:0] es,
                       output logic esg, output logic edb);
    logic [6:0]  s;
    logic [31:0] fixed;
    s = ref_enc(rd) ^ rc;
    fixed = rd; esg = 1'b0; edb = 1'b0;
    if (s != '0) begin
      if ($countones(s) == 1) esg = 1'b1;
      else begin
        for (int j = 0; j < 32; j++)
          if (s == ref_col(j)) begin fixed[j] = ~rd[j]; esg = 1'b1; end
        if (!esg) edb = 1'b1;
      end
    end
    case (mop)
      T_ENC: begin ed = rd; ec = ref_enc(rd); es = '0; esg = 1'b0; edb = 1'b0; end
      T_COR: begin ed = fixed; ec = ref_enc(fixed); es = s; end
      T_MRG: begin
        for (int k = 0; k < 4; k++)
          ed[k*8 +: 8] = be[k] ? wd[k*8 +: 8] : fixed[k*8 +: 8];
        ec = ref_enc(ed); es = s;
      end
      default: begin ed = rd; ec = rc; es = '0; esg = 1'b0; edb = 1'b0; end
    endcase
  endtask

  task automatic check_out_all(input string tag, input logic [31:0] ed, input logic [6:0] ec,
                               input logic [6:0] es, input logic esg, input logic edb);
    n_checks++;
    if (data_out !== ed || check_out !== ec || syndrome !== es ||
        single_err !== esg || double_err !== edb) begin
      n_errors++;
      $display("FAIL %s: got d=%h c=%h s=%h se=%b de=%b exp d=%h c=%h s=%h se=%b de=%b",
               tag, data_out, check_out, syndrome, single_err, double_err,
               ed, ec, es, esg, edb);
    end
  endtask

  task automatic apply(input logic [1:0] mop, input logic [31:0] rd, input logic [6:0] rc,
                       input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    op = mop; data_in = rd; check_in = rc; merge_data = wd; byte_sel = be; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag, input logic [1:0] mop, input logic [31:0] rd,
                          input logic [6:0] rc, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] ed; logic [6:0] ec; logic [6:0] es; logic esg; logic edb;
    apply(mop, rd, rc, wd, be);
    model(mop, rd, rc, wd, be, ed, ec, es, esg, edb);
    check_out_all(tag, ed, ec, es, esg, edb);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
    logic [38:0] err;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        exp_s;
    logic        exp_d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{T_ENC, 32'h0000_0000, 39'd0,                      32'h0, 4'h0, 1'b0, 1'b0},
    '{T_ENC, 32'hDEAD_BEEF, 39'd0,                      32'h0, 4'h0, 1'b0, 1'b0},
    '{T_COR, 32'h1234_5678, 39'd0,                      32'h0, 4'h0, 1'b0, 1'b0},
    '{T_COR, 32'hA5A5_A5A5, 39'd1,                      32'h0, 4'h0, 1'b1, 1'b0},
    '{T_COR, 32'hA5A5_A5A5, 39'd1 << 31,                32'h0, 4'h0, 1'b1, 1'b0},
    '{T_COR, 32'h0F1E_2D3C, 39'd1 << 32,                32'h0, 4'h0, 1'b1, 1'b0},
    '{T_COR, 32'h0F1E_2D3C, 39'd1 << 38,                32'h0, 4'h0, 1'b1, 1'b0},
    '{T_COR, 32'h5555_AAAA, (39'd1 << 3) | (39'd1 << 17), 32'h0, 4'h0, 1'b0, 1'b1},
    '{T_COR, 32'h5555_AAAA, (39'd1 << 5) | (39'd1 << 35), 32'h0, 4'h0, 1'b0, 1'b1},
    '{T_COR, 32'hFFFF_0000, (39'd1 << 33) | (39'd1 << 36), 32'h0, 4'h0, 1'b0, 1'b1},
    '{T_MRG, 32'hCAFE_F00D, 39'd1 << 9,                 32'h1122_3344, 4'b0101, 1'b1, 1'b0},
    '{T_MRG, 32'hCAFE_F00D, 39'd0,                      32'h1122_3344, 4'b1111, 1'b0, 1'b0},
    '{T_MRG, 32'h0BAD_CAFE, (39'd1 << 0) | (39'd1 << 30), 32'h99AA_BBCC, 4'b0011, 1'b0, 1'b1},
    '{T_DIA, 32'h0F0F_0F0F, 39'd1 << 12,                32'h0, 4'h0, 1'b0, 1'b0}
  };

  initial begin
    #(CLK_NS * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] base;
    logic [6:0]  good;
    logic [38:0] e;
    logic [31:0] ed; logic [6:0] ec; logic [6:0] es; logic esg; logic edb;

    // R1: outputs zero under reset
    repeat (3) @(negedge clk);
    check_out_all("R1 reset state", '0, '0, '0, 1'b0, 1'b0);
    rst = 1'b0;

    // Vector table (R3 R4 R5 R6 R7 R10 R11 R12)
    for (int i = 0; i < NV; i++) begin
      base = VECS[i].data;
      good = ref_enc(base);
      e = VECS[i].err;
      run_case($sformatf("R3-R12 table vec %0d", i), VECS[i].op, base ^ e[31:0],
               good ^ e[38:32], VECS[i].wd, VECS[i].be);
      if (VECS[i].op == T_COR || VECS[i].op == T_MRG) begin
        n_checks++;
        if (single_err !== VECS[i].exp_s || double_err !== VECS[i].exp_d) begin
          n_errors++;
          $display("FAIL R4/R5/R7 table class %0d: got se=%b de=%b exp se=%b de=%b",
                   i, single_err, double_err, VECS[i].exp_s, VECS[i].exp_d);
        end
      end
    end

    // R5 R6: every single-bit position
    base = 32'h6B1E_93C4;
    good = ref_enc(base);
    for (int b = 0; b < 39; b++) begin
      e = 39'd1 << b;
      apply(T_COR, base ^ e[31:0], good ^ e[38:32], '0, '0);
      es = (b < 32) ? ref_col(b) : (7'd1 << (b - 32));
      check_out_all($sformatf("R5/R6 single bit %0d", b), base, good, es, 1'b1, 1'b0);
    end

    // R7 R9: every double-bit position
    for (int a = 0; a < 39; a++) begin
      for (int b = a + 1; b < 39; b++) begin
        e = (39'd1 << a) | (39'd1 << b);
        apply(T_COR, base ^ e[31:0], good ^ e[38:32], '0, '0);
        model(T_COR, base ^ e[31:0], good ^ e[38:32], '0, '0, ed, ec, es, esg, edb);
        check_out_all($sformatf("R7 double bits %0d,%0d", a, b),
                      base ^ e[31:0], ref_enc(base ^ e[31:0]), es, 1'b0, 1'b1);
      end
    end

    // R8: gross stuck-at words
    apply(T_COR, 32'h0000_0000, 7'h00, '0, '0);
    n_checks++;
    if (double_err !== 1'b1 || single_err !== 1'b0) begin
      n_errors++;
      $display("FAIL R8 all-zero word: got se=%b de=%b exp se=0 de=1", single_err, double_err);
    end
    apply(T_COR, 32'hFFFF_FFFF, 7'h7F, '0, '0);
    n_checks++;
    if (double_err !== 1'b1 || single_err !== 1'b0) begin
      n_errors++;
      $display("FAIL R8 all-one word: got se=%b de=%b exp se=0 de=1", single_err, double_err);
    end

    // R10: every byte-select pattern over a repaired read
    base = 32'h3C5A_96E1;
    good = ref_enc(base);
    for (int s = 0; s < 16; s++)
      run_case($sformatf("R10 merge sel %0d", s), T_MRG, base ^ 32'h0001_0000, good,
               32'hF00D_BEEF, 4'(s));

    // R11: diagnostic with corrupted check bits
    run_case("R11 diag raw", T_DIA, 32'h1357_9BDF, 7'h55, '0, '0);

    // R2: inputs ignored while load is low
    run_case("R2 load", T_COR, 32'h2468_ACE0, ref_enc(32'h2468_ACE0) ^ 7'h04, '0, '0);
    model(T_COR, 32'h2468_ACE0, ref_enc(32'h2468_ACE0) ^ 7'h04, '0, '0, ed, ec, es, esg, edb);
    @(negedge clk);
    op = T_DIA; data_in = 32'hFFFF_FFFF; check_in = 7'h3A; merge_data = '1; byte_sel = '1;
    repeat (3) @(negedge clk);
    check_out_all("R2 hold without load", ed, ec, es, esg, edb);

    // R1: reset in mid-operation
    run_case("R1 pre-reset", T_COR, 32'h0, ref_enc(32'h0) ^ 7'h01, '0, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check_out_all("R1 mid-run reset", '0, '0, '0, 1'b0, 1'b0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule